// File: doc/BRIEF.md
# Single-Word MDIO Management Master

This block issues IEEE Clause 22 management frames on an MDC/MDIO pair. Software controls it through one 32-bit control word on a simple register bus. A single write holds everything for one transaction: the launch flag, the enable, the direction, the two addresses and the write data. The block then clocks the frame out on MDC/MDIO. When the frame ends, it clears the launch flag on its own.

Software polls the flag until it reads zero. For a read, the 16 bits captured from the PHY are then in the low field of the same word. MDC is derived from the system clock by a parameterised divider. The default suits a 50 MHz system clock and gives 2.5 MHz.

Top module: `mdio_ctrl_master`

## Requirements
- R1: After reset the control word reads zero, MDC is low and MDIO is not driven. Whenever no transaction is in progress, MDC stays low and MDIO stays released.
- R2: A write that has bit 31 (busy) and bit 30 (enable) both set starts a transaction. Busy reads 1 from the next cycle and returns to 0 exactly 64 MDC periods (128·HALF_DIV system cycles) after the launching write.
- R3: A write with bit 30 clear starts nothing. Busy reads 0, MDC stays low, and bits 30:0 of the written word are stored.
- R4: With bit 27 clear, the frame is a write. It consists of 32 ones, start 01, opcode 01, PHY address from bits 25:21, register address from bits 20:16, turnaround 10 and data from bits 15:0. Everything is sent MSB first, and the master drives all 64 bits.
- R5: With bit 27 set, the frame is a read with opcode 10. The master drives only the first 46 bits and releases MDIO for the turnaround and the 16 data bits.
- R6: On read completion, bits 15:0 hold the 16 bits sampled on the rising MDC edges of the data phase, first bit in bit 15. Bits 30:16 keep their written value.
- R7: Any write that arrives while busy reads 1 is ignored. This includes a write in the cycle the frame completes.
- R8: MDC high and low phases each last HALF_DIV system cycles, so the rising edges are 2·HALF_DIV cycles apart.
- R9: MDIO output value and drive enable change only while MDC is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Current control word |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
Frame completion and a new software write can fall in the same cycle. Completion clears busy and loads the read data, while the write would otherwise relaunch the block. The bench times a complete launch word to land on exactly the edge where the last MDC falling edge retires the read. It then expects the word to show busy clear and the captured data intact. It also expects MDC to stay low afterwards, which shows that the colliding write was dropped rather than starting a second frame.

// File: rtl/mdio_mst_pkg.sv
package mdio_mst_pkg;
  localparam int CTRL_W    = 32;
  localparam int BUSY_BIT  = 31;
  localparam int EN_BIT    = 30;
  localparam int RD_BIT    = 27;
  localparam int PHY_LSB   = 21;
  localparam int REG_LSB   = 16;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int PRE_W     = 32;
  localparam int FRAME_W   = PRE_W + 2 + 2 + 2*ADDR_W + 2 + DATA_W;
  localparam int DRIVE_RD  = PRE_W + 2 + 2 + 2*ADDR_W;
  localparam int DATA_POS  = FRAME_W - DATA_W;
  localparam int CNT_W     = $clog2(FRAME_W);
endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
  parameter int HALF_DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == LAST);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_mst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] REL_BIT   = CNT_W'(DRIVE_RD);
  localparam logic [CNT_W-1:0] FIRST_DAT = CNT_W'(DATA_POS);

  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   bit_q;
  logic               rd_q;
  logic               act_q;
  logic [DATA_W-1:0]  cap_q;
  logic [FRAME_W-1:0] frame;

  always_comb begin
    frame = {{PRE_W{1'b1}}, 2'b01, (rd_i ? 2'b10 : 2'b01), phy_i, reg_i,
             (rd_i ? 2'b00 : 2'b10), (rd_i ? {DATA_W{1'b0}} : wdata_i)};
  end

  assign done_o    = act_q && fall_i && (bit_q == LAST_BIT);
  assign mdio_o    = act_q ? sr_q[FRAME_W-1] : 1'b1;
  assign mdio_oe_o = act_q && (!rd_q || (bit_q < REL_BIT));
  assign rdata_o   = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      bit_q <= '0;
      rd_q  <= 1'b0;
      act_q <= 1'b0;
      cap_q <= '0;
    end else if (start_i) begin
      sr_q  <= frame;
      bit_q <= '0;
      rd_q  <= rd_i;
      act_q <= 1'b1;
    end else if (act_q) begin
      // PHY output is sampled on the rising MDC edge of each data bit
      if (rise_i && rd_q && (bit_q >= FIRST_DAT))
        cap_q <= {cap_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (bit_q == LAST_BIT) begin
          act_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 1'b1;
          sr_q  <= {sr_q[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_ctrl_master.sv
module mdio_ctrl_master
  import mdio_mst_pkg::*;
#(
  parameter int HALF_DIV = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic [CTRL_W-1:0] reg_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              busy;
  logic              start;
  logic              rise, fall, done;
  logic [DATA_W-1:0] cap;

  assign busy        = ctrl_q[BUSY_BIT];
  assign start       = reg_wr_i && !busy && reg_wdata_i[BUSY_BIT] && reg_wdata_i[EN_BIT];
  assign reg_rdata_o = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (reg_wr_i && !busy) begin
      ctrl_q <= {start, reg_wdata_i[CTRL_W-2:0]};
    end else if (done) begin
      ctrl_q[BUSY_BIT] <= 1'b0;
      if (ctrl_q[RD_BIT]) ctrl_q[DATA_W-1:0] <= cap;
    end
  end

  mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .rd_i      (reg_wdata_i[RD_BIT]),
    .phy_i     (reg_wdata_i[PHY_LSB +: ADDR_W]),
    .reg_i     (reg_wdata_i[REG_LSB +: ADDR_W]),
    .wdata_i   (reg_wdata_i[DATA_W-1:0]),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_o    (done),
    .rdata_o   (cap)
  );
endmodule

// File: rtl/mdio_ctrl_master_chk.sv
module mdio_ctrl_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_wr_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  assert_idle_pins_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[31] |-> (!mdc_o && !mdio_oe_o));

  assert_no_launch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !reg_rdata_o[31] && !reg_wdata_i[30]) |=> (!reg_rdata_o[31] && !mdc_o));

  assert_fields_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[31] |=> (reg_rdata_o[30:16] == $past(reg_rdata_o[30:16])));

  assert_change_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));
endmodule

bind mdio_ctrl_master mdio_ctrl_master_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .mdc_o       (mdc_o),
  .mdio_o      (mdio_o),
  .mdio_oe_o   (mdio_oe_o)
);

// File: tb/tb_mdio_ctrl_master.sv
`timescale 1ns/1ps
module tb_mdio_ctrl_master;
  localparam int HALF = 10;
  localparam int TXN  = 128 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdo, mdoe;
  logic        mdi = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  int rise_idx = 0;
  int hazards = 0;
  logic [63:0] cap_v, cap_e;
  logic [15:0] reply = '0;
  time t_r0, t_r1;
  logic p_mdc = 1'b0, p_o = 1'b1, p_oe = 1'b0;

  always #10 clk = ~clk;

  mdio_ctrl_master #(.HALF_DIV(HALF)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(mdoe), .mdio_i(mdi)
  );

  // bus monitor and PHY responder
  always @(posedge mdc) begin
    if (rise_idx < 64) begin
      cap_v[63-rise_idx] = mdo;
      cap_e[63-rise_idx] = mdoe;
    end
    if (rise_idx == 0) t_r0 = $time;
    if (rise_idx == 1) t_r1 = $time;
    rise_idx = rise_idx + 1;
  end

  always @(negedge mdc) begin
    if (rise_idx >= 48 && rise_idx < 64) mdi = reply[63-rise_idx];
    else mdi = 1'b1;
  end

  always @(negedge clk) begin
    if (mdc && p_mdc && (mdo !== p_o || mdoe !== p_oe)) hazards = hazards + 1;
    p_mdc = mdc; p_o = mdo; p_oe = mdoe;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit rd, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    return {1'b1, 1'b1, 2'b00, rd, 1'b0, phy, ra, d};
  endfunction

  function automatic logic [63:0] frame_of(input bit rd, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : d)};
  endfunction

  task automatic reg_write(input logic [31:0] w);
    @(negedge clk); wr = 1'b1; wdata = w;
    @(negedge clk); wr = 1'b0;
  endtask

  // launch and check busy timing; returns after completion edge
  task automatic run_txn(input logic [31:0] w);
    rise_idx = 0; cap_v = '0; cap_e = '0;
    reg_write(w);
    chk(rdata[31] === 1'b1, "R2 busy after launch", {32'h0, rdata}, 64'h8000_0000);
    repeat (TXN - 1) @(negedge clk);
    chk(rdata[31] === 1'b1, "R2 busy one cycle before end", {63'h0, rdata[31]}, 64'h1);
    @(negedge clk);
    chk(rdata[31] === 1'b0, "R2 busy clear at end", {63'h0, rdata[31]}, 64'h0);
  endtask

  task automatic t_reset();
    chk(rdata === 32'h0, "R1 reset word", {32'h0, rdata}, 64'h0);
    chk(mdc === 1'b0 && mdoe === 1'b0, "R1 reset pins", {62'h0, mdc, mdoe}, 64'h0);
  endtask

  task automatic t_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    logic [31:0] w = mk(1'b0, phy, ra, d);
    run_txn(w);
    chk(cap_v === frame_of(1'b0, phy, ra, d), "R4 write frame bits", cap_v, frame_of(1'b0, phy, ra, d));
    chk(cap_e === {64{1'b1}}, "R4 write fully driven", cap_e, {64{1'b1}});
    chk(rdata === {1'b0, w[30:0]}, "R4 word after write", {32'h0, rdata}, {33'h0, w[30:0]});
    chk(rise_idx == 64, "R2 64 MDC periods", 64'(rise_idx), 64'd64);
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] r);
    logic [31:0] w = mk(1'b1, phy, ra, 16'hFFFF);
    logic [63:0] fe = frame_of(1'b1, phy, ra, 16'h0);
    reply = r;
    run_txn(w);
    chk(cap_v[63:18] === fe[63:18], "R5 read header bits", {18'h0, cap_v[63:18]}, {18'h0, fe[63:18]});
    chk(cap_e === {{46{1'b1}}, 18'h0}, "R5 release window", cap_e, {{46{1'b1}}, 18'h0});
    chk(rdata === {1'b0, w[30:16], r}, "R6 read data returned", {32'h0, rdata}, {32'h0, 1'b0, w[30:16], r});
  endtask

  task automatic t_no_enable();
    logic [31:0] w = mk(1'b0, 5'd9, 5'd4, 16'h5A5A) & 32'hBFFF_FFFF;
    rise_idx = 0;
    reg_write(w);
    repeat (100) @(negedge clk);
    chk(rdata === {1'b0, w[30:0]}, "R3 stored without launch", {32'h0, rdata}, {33'h0, w[30:0]});
    chk(rise_idx == 0 && mdc === 1'b0, "R3 no MDC activity", 64'(rise_idx), 64'd0);
  endtask

  task automatic t_busy_write();
    logic [31:0] w = mk(1'b0, 5'd1, 5'd2, 16'h1357);
    rise_idx = 0; cap_v = '0;
    reg_write(w);
    repeat (100) @(negedge clk);
    wr = 1'b1; wdata = mk(1'b1, 5'd30, 5'd29, 16'hFFFF);
    @(negedge clk); wr = 1'b0;
    repeat (TXN) @(negedge clk);
    chk(cap_v === frame_of(1'b0, 5'd1, 5'd2, 16'h1357), "R7 frame unaffected", cap_v, frame_of(1'b0, 5'd1, 5'd2, 16'h1357));
    chk(rdata === {1'b0, w[30:0]}, "R7 word unaffected", {32'h0, rdata}, {33'h0, w[30:0]});
  endtask

  task automatic t_collision();
    logic [31:0] w = mk(1'b1, 5'd3, 5'd2, 16'h0000);
    reply = 16'hBEEF;
    rise_idx = 0;
    reg_write(w);
    repeat (TXN - 1) @(negedge clk);
    wr = 1'b1; wdata = mk(1'b0, 5'd5, 5'd6, 16'h1234);
    @(negedge clk); wr = 1'b0;
    chk(rdata === {1'b0, w[30:16], 16'hBEEF}, "R7 completion-cycle write dropped", {32'h0, rdata}, {32'h0, 1'b0, w[30:16], 16'hBEEF});
    rise_idx = 0;
    repeat (60) @(negedge clk);
    chk(rise_idx == 0 && rdata[31] === 1'b0, "R7 no relaunch", 64'(rise_idx), 64'd0);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write(5'd17, 5'd4, 16'hA5C3);
    chk((t_r1 - t_r0) == time'(2 * HALF * 20), "R8 MDC period", 64'(t_r1 - t_r0), 64'(2 * HALF * 20));
    t_write(5'd0, 5'd31, 16'h0001);
    t_read(5'd22, 5'd1, 16'h8001);
    t_read(5'd31, 5'd0, 16'h6C39);
    t_no_enable();
    t_busy_write();
    t_collision();
    chk(hazards == 0, "R9 MDIO changes only while MDC low", 64'(hazards), 64'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule